// File: doc/BRIEF.md
# Presence-Detect Serial Memory Target

This block is a two-wire serial bus (I2C) target that holds 256 bytes of module description data. The lower half of the memory is loaded with fixed identity and timing contents at reset and cannot be overwritten from the bus. The upper half is free for the host to write. A system clock samples the bus lines through glitch filters. START and STOP conditions are recognised from SDA edges while SCL is high. The data output is an open-drain enable: when it is 1, the pad pulls SDA low.

The device address is the fixed nibble `1010` followed by three strap inputs, so up to eight targets can share one bus. After its address is acknowledged for writing, the first byte the host sends loads an internal byte pointer. Each further byte is stored at the pointer. The pointer steps by one for every byte read or written and wraps from 255 to 0. A repeated START lets the host set the pointer and then switch to reading without releasing the bus. When a STOP ends a transfer that stored data, the target stays silent to its own address for a programmable number of clock cycles. This models the time a real memory needs to program the bytes.

Top module: `spd_target`

## Requirements
- R1: After reset `sda_oe_o` is 0, and SCL/SDA activity that does not begin with a START never makes the target pull SDA low.
- R2: The address byte is `{1010, strap_i[2:0], rw}` sent MSB first. On a match the target pulls SDA low during the ninth clock. On a mismatch it never drives SDA until the next START.
- R3: In a write transfer (rw = 0), the first byte after the address loads the byte pointer. Every byte received, pointer byte included, is acknowledged.
- R4: Byte i (0 to 127) resets to (i*29 + 0x17) mod 256, and bytes 128 to 255 reset to 0xFF. Writes to bytes 0 to 127 are acknowledged but leave the contents unchanged. Writes to bytes 128 to 255 are stored.
- R5: A read (rw = 1) sends the byte at the pointer MSB first and then advances the pointer. Both reads and writes step the pointer by one per byte, wrapping from 255 to 0.
- R6: In a read, after each byte the target releases SDA and samples the host acknowledge on the ninth clock. When SDA is high there, the target sends nothing more until a START or STOP.
- R7: A repeated START (no STOP) restarts address matching, keeping the pointer, so a pointer set by a write transfer is used by the following read.
- R8: After a STOP that ends a transfer in which at least one data byte was written, the address is not acknowledged for `WR_CYCLES` clock cycles. It is acknowledged again after that window. A STOP after a pointer-only write starts no such window.
- R9: A pulse on SCL or SDA shorter than `FILT_CYCLES` clock cycles has no effect on the bus protocol.
- R10: `sda_oe_o` changes only while the filtered SCL is low.
- R11: A STOP ends any transfer: the target releases SDA and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Address strap inputs, low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that the host follows the bus rules. It changes SDA only while SCL is low, except when it makes a START or STOP, and it never makes a START or STOP while the target is pulling SDA low. They also assume that every intended level on either line lasts longer than the filter window. The stimulus meets these assumptions by spacing all host edges a quarter bit period apart, well above the filter and synchroniser delay. The host always ends a read with a not-acknowledge before STOP, and it injects short pulses only while the other line is steady. Random pointers, lengths, data and strap values run between directed cases for protection, wrap, busy window and glitch rejection.

// File: rtl/spd_pkg.sv
// Shared types and constants for the presence-detect serial memory target.
// Assumes an 8-bit byte pointer and a 256-byte store.
package spd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_RX,      // shifting in a byte
        ST_ACKSET,  // byte taken, drive acknowledge on next SCL fall
        ST_ACKHOLD, // acknowledge driven, release on next SCL fall
        ST_TX,      // shifting out a byte
        ST_TXACK,   // sample host acknowledge on SCL rise
        ST_TXNEXT,  // host acknowledged, load next byte on SCL fall
        ST_WAIT     // silent until START or STOP
    } spd_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } spd_kind_e;

    localparam logic [3:0] SPD_PREFIX = 4'b1010;

    // Reset content of the protected half: byte i holds i*29 + 0x17.
    function automatic logic [7:0] spd_rom_byte(input logic [7:0] idx);
        return idx * 8'd29 + 8'h17;
    endfunction

endpackage

// File: rtl/spd_deglitch.sv
// Two-flop synchroniser followed by a stability filter. The output takes a
// new level only after the synchronised input has held it for FILT_CYCLES
// consecutive clocks. Assumes the idle line level is high.
module spd_deglitch #(
    parameter int FILT_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    // Synchronise and accept a new level only once it has been stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign line_o = level_q;

    // R9
    follow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(sync_q[1]) == level_q));

endmodule

// File: rtl/spd_bus_events.sv
// Turns filtered SCL/SDA levels into one-cycle events: SCL rise and fall,
// and START / STOP (SDA edge while SCL stays high). Assumes filtered inputs.
module spd_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/spd_store.sv
// 2^ADDR_W byte store. The lower half is loaded by reset and locked against
// writes; the upper half resets to 0xFF and accepts writes. Reads are
// combinational from raddr_i.
module spd_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    import spd_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LOCKED = DEPTH / 2;

    logic [7:0] mem [DEPTH];

    // Load identity contents at reset; store writes to the open half only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < LOCKED) ? spd_rom_byte(8'(i)) : 8'hFF;
            end
        end else if (we_i && waddr_i[ADDR_W-1]) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

    // R4
    lower_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !waddr_i[ADDR_W-1]) |=> (mem[$past(waddr_i)] == $past(mem[waddr_i])));

endmodule

// File: rtl/spd_target.sv
// Two-wire serial bus target for a 256-byte presence-detect store.
// Address {1010, strap}, pointer-then-data writes, auto-increment reads,
// repeated START, and a busy window after a STOP that ended a write.
// Assumes a host that changes SDA only while SCL is low outside START/STOP.
module spd_target #(
    parameter int FILT_CYCLES = 25,
    parameter int WR_CYCLES   = 2_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    import spd_pkg::*;

    localparam int ADDR_W = 8;
    localparam int BW     = $clog2(WR_CYCLES + 1);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start, stop;

    spd_state_e        st_q;
    spd_kind_e         kind_q;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q;
    logic              wrote_q;
    logic              oe_q;
    logic [BW-1:0]     busy_q;

    logic [7:0] rx_byte;
    logic [7:0] rdata;
    logic       we;

    spd_deglitch #(.FILT_CYCLES(FILT_CYCLES)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    spd_deglitch #(.FILT_CYCLES(FILT_CYCLES)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    spd_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start), .stop_o(stop));

    assign rx_byte = {shreg_q[6:0], sda_f};
    assign we = (st_q == ST_RX) && scl_rise && !start && !stop &&
                (bitcnt_q == 4'd7) && (kind_q == K_DATA);

    spd_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr_q),
        .wdata_i(rx_byte), .raddr_i(ptr_q), .rdata_o(rdata));

    // Busy window: armed by a STOP closing a write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (stop && wrote_q) begin
            busy_q <= BW'(WR_CYCLES);
        end else if (busy_q != '0) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    // Protocol sequencer: address match, acknowledge, receive and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            kind_q   <= K_ADDR;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            wrote_q  <= 1'b0;
            oe_q     <= 1'b0;
        end else if (start) begin
            st_q     <= ST_RX;
            kind_q   <= K_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else if (stop) begin
            st_q    <= ST_IDLE;
            oe_q    <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            case (st_q)
                ST_RX: if (scl_rise) begin
                    shreg_q  <= rx_byte;
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == 4'd7) begin
                        case (kind_q)
                            K_ADDR: begin
                                if (rx_byte[7:1] == {SPD_PREFIX, strap_i} && busy_q == '0) begin
                                    rw_q <= rx_byte[0];
                                    st_q <= ST_ACKSET;
                                end else begin
                                    st_q <= ST_WAIT;
                                end
                            end
                            K_PTR: begin
                                ptr_q  <= rx_byte;
                                kind_q <= K_DATA;
                                st_q   <= ST_ACKSET;
                            end
                            default: begin
                                ptr_q   <= ptr_q + 1'b1;
                                wrote_q <= 1'b1;
                                st_q    <= ST_ACKSET;
                            end
                        endcase
                    end
                end
                ST_ACKSET: if (scl_fall) begin
                    oe_q <= 1'b1;
                    st_q <= ST_ACKHOLD;
                end
                ST_ACKHOLD: if (scl_fall) begin
                    bitcnt_q <= '0;
                    if (kind_q == K_ADDR && rw_q) begin
                        shreg_q <= rdata;
                        ptr_q   <= ptr_q + 1'b1;
                        oe_q    <= ~rdata[7];
                        st_q    <= ST_TX;
                    end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_RX;
                        if (kind_q == K_ADDR) kind_q <= K_PTR;
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            oe_q <= 1'b0;
                            st_q <= ST_TXACK;
                        end else begin
                            shreg_q <= {shreg_q[6:0], 1'b0};
                            oe_q    <= ~shreg_q[6];
                        end
                    end
                end
                ST_TXACK: if (scl_rise) begin
                    st_q <= sda_f ? ST_WAIT : ST_TXNEXT;
                end
                ST_TXNEXT: if (scl_fall) begin
                    shreg_q  <= rdata;
                    ptr_q    <= ptr_q + 1'b1;
                    oe_q     <= ~rdata[7];
                    bitcnt_q <= '0;
                    st_q     <= ST_TX;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_oe_o);

    // R6
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> !sda_oe_o);

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0) |-> !(st_q == ST_ACKSET && kind_q == K_ADDR));

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) && !$past(start) && !$past(stop) |-> !$past(scl_f));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (st_q == ST_IDLE) && !sda_oe_o);

endmodule

// File: tb/spd_target_test.sv
// Self-checking bench: bus host tasks, a byte model of the store, seeded
// random transfers and directed corner cases.
module spd_target_test;

    localparam int FILT = 4;
    localparam int WR   = 2000;
    localparam int Q    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1, sda_drv = 1'b1;
    logic       scl_gl = 1'b0, sda_gl = 1'b0;
    logic [2:0] strap = 3'd5;
    logic       oe;
    logic       scl_bus, sda_bus;

    int nvec = 0, nfail = 0;
    bit done = 0;
    logic [7:0] model [256];

    assign scl_bus = scl_drv | scl_gl;
    assign sda_bus = sda_drv & ~sda_gl & ~oe;

    always #2 clk = ~clk;

    spd_target #(.FILT_CYCLES(FILT), .WR_CYCLES(WR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .strap_i(strap), .sda_oe_o(oe));

    function automatic logic [7:0] reset_val(input int i);
        return (i < 128) ? 8'((i * 29 + 23) % 256) : 8'hFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_drv = b; tick(Q / 2);
        if (glitch) begin scl_gl = 1'b1; tick(FILT - 2); scl_gl = 1'b0; end
        tick(Q / 2);
        scl_drv = 1'b1; tick(2 * Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack, input bit glitch = 0);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 4);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(!give_ack, 0);
    endtask

    function automatic logic [7:0] addr(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    // Write len bytes from ptr; checks every acknowledge, then waits out busy.
    task automatic write_run(input logic [7:0] ptr, input int len, input logic [7:0] d [4]);
        bit ack;
        bus_start();
        send_byte(addr(0), ack); check(ack, "R2 write address ack", ack, 1);
        send_byte(ptr, ack);     check(ack, "R3 pointer byte ack", ack, 1);
        for (int k = 0; k < len; k++) begin
            logic [7:0] p;
            p = ptr + 8'(k);
            send_byte(d[k], ack); check(ack, "R3 data byte ack", ack, 1);
            if (p >= 8'd128) model[p] = d[k];
        end
        bus_stop();
        tick(WR + 64);
    endtask

    // Set pointer, repeated START, read len bytes and compare with the model.
    task automatic read_run(input logic [7:0] ptr, input int len, input string req);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte(addr(0), ack); check(ack, "R7 address ack", ack, 1);
        send_byte(ptr, ack);     check(ack, "R7 pointer ack", ack, 1);
        bus_start();
        send_byte(addr(1), ack); check(ack, "R7 read address ack after repeated START", ack, 1);
        for (int k = 0; k < len; k++) begin
            logic [7:0] p;
            p = ptr + 8'(k);
            recv_byte(v, k != len - 1);
            check(v == model[p], req, v, model[p]);
        end
        bus_stop();
        check(!oe, "R11 released after STOP", oe, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] v;
        logic [7:0] d [4];
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) model[i] = reset_val(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(!oe, "R1 reset output released", oe, 0);

        // R1: clock a matching address without a START: no acknowledge.
        send_byte(addr(0), ack);
        check(!ack, "R1 no ack without START", ack, 0);
        bus_stop();

        // R2: wrong address, then a further byte: never driven.
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, ack); check(!ack, "R2 mismatch prefix nack", ack, 0);
        send_byte(8'h00, ack);                  check(!ack, "R2 silent after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, ~strap, 1'b0}, ack); check(!ack, "R2 mismatch strap nack", ack, 0);
        bus_stop();

        // R4: reset contents in both halves.
        read_run(8'd0, 3, "R4 lower half reset value");
        read_run(8'd126, 4, "R4 boundary reset values");

        // R3/R4: write upper bytes, read back.
        d = '{8'h3C, 8'hA5, 8'h00, 8'h7E};
        write_run(8'd200, 4, d);
        read_run(8'd200, 4, "R3 upper write readback");

        // R4: write to protected bytes is acked but ignored.
        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_run(8'd10, 2, d);
        read_run(8'd10, 2, "R4 protected byte unchanged");

        // R5: wrap from 255 to 0 on write and read.
        d = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
        write_run(8'd254, 3, d);
        read_run(8'd254, 4, "R5 pointer wrap");

        // R8: busy window after a write STOP.
        bus_start();
        send_byte(addr(0), ack); send_byte(8'd150, ack);
        send_byte(8'h5A, ack); model[150] = 8'h5A;
        bus_stop();
        bus_start();
        send_byte(addr(0), ack); check(!ack, "R8 nack inside busy window", ack, 0);
        bus_stop();
        tick(WR);
        bus_start();
        send_byte(addr(0), ack); check(ack, "R8 ack after busy window", ack, 1);
        send_byte(8'd150, ack);
        bus_stop();
        bus_start();
        send_byte(addr(0), ack); check(ack, "R8 pointer-only write arms no busy", ack, 1);
        bus_stop();

        // R6: host nack, then the target must stay silent.
        bus_start();
        send_byte(addr(0), ack); send_byte(8'd40, ack);
        bus_start();
        send_byte(addr(1), ack);
        recv_byte(v, 0);
        check(v == model[40], "R6 byte before nack", v, model[40]);
        recv_byte(v, 0);
        check(v == 8'hFF, "R6 silent after host nack", v, 8'hFF);
        bus_stop();

        // R9: short SDA pulse while SCL high is no START.
        tick(Q);
        sda_gl = 1'b1; tick(FILT - 2); sda_gl = 1'b0; tick(Q);
        send_byte(addr(0), ack);
        check(!ack, "R9 SDA glitch is no START", ack, 0);
        bus_stop();

        // R9: short SCL pulse inside a data byte adds no bit.
        bus_start();
        send_byte(addr(0), ack); send_byte(8'd170, ack);
        send_byte(8'h96, ack, 1);
        check(ack, "R9 ack with SCL glitch", ack, 1);
        model[170] = 8'h96;
        bus_stop();
        tick(WR + 64);
        read_run(8'd170, 1, "R9 SCL glitch data intact");

        // Random transfers over the open half with random straps.
        for (int t = 0; t < 6; t++) begin
            int len;
            logic [7:0] p;
            strap = 3'($urandom);
            p = 8'd128 + 8'($urandom_range(0, 127));
            len = $urandom_range(1, 4);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            write_run(p, len, d);
            read_run(p, len, "R5 random write/read");
        end

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule